// File: doc/BRIEF.md
# Two-Wire Serial Converter Output Port

This block models the digital side of a single-channel 16-bit converter that talks to a host over two wires. Chip select is held low. The host drives a serial clock, and the block drives one data output. That output serves two purposes. During a conversion it is held high as a busy flag. Afterwards it carries the result, most significant bit first.

The conversion itself is not modelled as analog work. A counter of system clock cycles stands in for it. When the count completes, the 16-bit word present on a parallel test port is captured.

The serial clock is synchronised into the system clock domain and reduced to rising and falling edge strobes. A configuration input selects the idle level of the serial clock, and that choice changes the sequence:

- **Idle-high clock:** the block first parks in a sleep state with the output low, which signals that a result is ready. Sixteen pulses move the word out, and the seventeenth pulse starts a new conversion.
- **Idle-low clock:** the block goes straight to data output with the top bit already on the pin. The sixteenth falling edge starts a new conversion.

Top module: `serial_adc_link`

## Requirements
- R1: While reset is asserted, and immediately after it, the block is converting and `sdo` is 1.
- R2: A conversion occupies exactly CONV_CYCLES system clock edges. After the synchronous reset is released, `sdo` is still busy after edge CONV_CYCLES-1 and shows the finished state after edge CONV_CYCLES.
- R3: Serial clock edges that arrive during a conversion are ignored. `sdo` stays 1, and those edges are not counted toward the readout that follows.
- R4: The result is the value on `test_result` at the edge that ends the conversion. Changing the port afterwards does not alter the bits shifted out.
- R5: With `cpol_idle_high`=1, the block enters sleep when the conversion ends. `sdo` goes to 0 and stays 0 until the first falling edge of `sck`.
- R6: With `cpol_idle_high`=1, falling edge n of `sck` (n = 1..16) places result bit 16-n on `sdo`, so the bits appear bit 15 first and bit 0 last.
- R7: With `cpol_idle_high`=1, the 17th falling edge of `sck` starts a new conversion and `sdo` returns to 1.
- R8: With `cpol_idle_high`=0, the sleep state is skipped. When the conversion ends, `sdo` shows bit 15 of the result at once.
- R9: With `cpol_idle_high`=0, falling edge n (n = 1..15) places bit 15-n on `sdo`, and rising edges of `sck` leave `sdo` unchanged.
- R10: With `cpol_idle_high`=0, the 16th falling edge of `sck` starts a new conversion and `sdo` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host, asynchronous to `clk` |
| cpol_idle_high | input | 1 | 1 = serial clock idles high, 0 = idles low |
| test_result | input | 16 (W) | Parallel result captured at the end of each conversion |
| sdo | output | 1 | Busy flag during conversion, ready flag in sleep, result bits in data output |

## Verification
The readout is exercised with both clock polarities, using several result words:
- An alternating mix of ones and zeros exposes bit-order or off-by-one shift errors.
- An all-ones word and an all-zeros word show whether the busy level or the ready level is being confused with data.
- Words with only the end bits set separate the first and last shift positions.

Clock pulses applied during each conversion show whether convert-state edges leak into the bit count. Changing the test port after capture shows whether data is taken live rather than latched. An exact cycle count after reset pins down the conversion length.

// File: rtl/adc_link_pkg.sv
package adc_link_pkg;
  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_DATA  = 2'd2
  } link_state_e;
endpackage

// File: rtl/sck_edge_sync.sv
// Brings the host serial clock into the system domain and reports its edges.
module sck_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_in,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= sck_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], sck_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
  assign fall = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/conv_timer.sv
// Counts system clock cycles while a conversion runs; done marks the final one.
module conv_timer #(
  parameter int CONV_CYCLES = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || done) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/result_shifter.sv
// Holds the captured word and moves it toward the top bit one place per shift.
module result_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         head,
  output logic         next_bit
);
  logic [W-1:0] sreg_q;

  always_ff @(posedge clk) begin
    if (rst)        sreg_q <= '0;
    else if (load)  sreg_q <= din;
    else if (shift) sreg_q <= {sreg_q[W-2:0], 1'b0};
  end

  assign head     = sreg_q[W-1];
  assign next_bit = sreg_q[W-2];
endmodule

// File: rtl/serial_adc_link.sv
// Convert / sleep / data-output sequencer driving a shared busy-and-data pin.
module serial_adc_link
  import adc_link_pkg::*;
#(
  parameter int W           = 16,
  parameter int CONV_CYCLES = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sck,
  input  logic         cpol_idle_high,
  input  logic [W-1:0] test_result,
  output logic         sdo
);
  localparam int BW = $clog2(W);
  localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

  link_state_e   state_q, state_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          sdo_q, sdo_d;
  logic          sck_rise, sck_fall;
  logic          conv_done;
  logic          sh_load, sh_shift, sh_head, sh_next;

  sck_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .sck_in (sck),
    .rise   (sck_rise),
    .fall   (sck_fall)
  );

  conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (state_q == ST_CONV),
    .done (conv_done)
  );

  result_shifter #(.W(W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (sh_load),
    .shift    (sh_shift),
    .din      (test_result),
    .head     (sh_head),
    .next_bit (sh_next)
  );

  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    sdo_d    = sdo_q;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state_q)
      ST_CONV: begin
        sdo_d = 1'b1;
        if (conv_done) begin
          sh_load = 1'b1;
          bit_d   = '0;
          if (cpol_idle_high) begin
            state_d = ST_SLEEP;
            sdo_d   = 1'b0;
          end else begin
            state_d = ST_DATA;
            sdo_d   = test_result[W-1];
          end
        end
      end
      ST_SLEEP: begin
        if (sck_fall) begin
          state_d = ST_DATA;
          bit_d   = '0;
          sdo_d   = sh_head;
        end
      end
      ST_DATA: begin
        if (sck_fall) begin
          if (bit_q == LAST_BIT) begin
            state_d = ST_CONV;
            sdo_d   = 1'b1;
          end else begin
            sh_shift = 1'b1;
            bit_d    = bit_q + 1'b1;
            sdo_d    = sh_next;
          end
        end
      end
      default: begin
        state_d = ST_CONV;
        sdo_d   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_CONV;
      bit_q   <= '0;
      sdo_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sdo_q   <= sdo_d;
    end
  end

  assign sdo = sdo_q;
endmodule

// File: rtl/adc_link_chk.sv
module adc_link_chk
  import adc_link_pkg::*;
#(
  parameter int W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input link_state_e          state_q,
  input logic [$clog2(W)-1:0] bit_q,
  input logic                 conv_done,
  input logic                 sck_rise,
  input logic                 sck_fall,
  input logic                 cpol_idle_high,
  input logic                 sdo
);
  assert_busy_high_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONV) |-> sdo);

  assert_sleep_low_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP) |-> !sdo);

  assert_sleep_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP && !sck_fall) |=> (state_q == ST_SLEEP));

  assert_to_sleep_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONV && conv_done && cpol_idle_high) |=> (state_q == ST_SLEEP));

  assert_skip_sleep_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONV && conv_done && !cpol_idle_high) |=> (state_q == ST_DATA));

  assert_rise_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATA && sck_rise && !sck_fall) |=> $stable(sdo));

  assert_last_edge_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATA && sck_fall && bit_q == ($clog2(W))'(W - 1)) |=> (state_q == ST_CONV && sdo));
endmodule

bind serial_adc_link adc_link_chk #(.W(W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .state_q        (state_q),
  .bit_q          (bit_q),
  .conv_done      (conv_done),
  .sck_rise       (sck_rise),
  .sck_fall       (sck_fall),
  .cpol_idle_high (cpol_idle_high),
  .sdo            (sdo)
);

// File: tb/sim_serial_adc_link.sv
`timescale 1ns/1ps
module sim_serial_adc_link;
  localparam int W    = 16;
  localparam int CONV = 150;
  localparam int HALF = 6;

  localparam logic [16:0] VEC [6] = '{
    {1'b1, 16'hA5C3}, {1'b0, 16'h3C96}, {1'b1, 16'hFFFF},
    {1'b0, 16'h0000}, {1'b1, 16'h8001}, {1'b0, 16'h7FFE}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sck = 1'b1;
  logic         cpol = 1'b1;
  logic [W-1:0] tres = 16'h5A69;
  logic         sdo;
  int           checks = 0;
  int           errors = 0;
  bit           finished = 1'b0;

  always #5 clk = ~clk;

  serial_adc_link #(.W(W), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) u0 (
    .clk            (clk),
    .rst            (rst),
    .sck            (sck),
    .cpol_idle_high (cpol),
    .test_result    (tres),
    .sdo            (sdo)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: sdo=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Shift out one captured word; the test port has already been scrambled (R4).
  task automatic readout(input logic pol, input logic [W-1:0] word);
    if (pol) begin
      chk("R5", sdo, 1'b0);
      tick(30);
      chk("R5", sdo, 1'b0);
      for (int i = 0; i < W; i++) begin
        sck = 1'b0; tick(HALF);
        chk("R6 R4", sdo, word[W-1-i]);
        sck = 1'b1; tick(HALF);
      end
      sck = 1'b0; tick(HALF);
      chk("R7", sdo, 1'b1);
      sck = 1'b1; tick(HALF);
      chk("R7", sdo, 1'b1);
    end else begin
      chk("R8 R4", sdo, word[W-1]);
      for (int i = 0; i < W; i++) begin
        sck = 1'b1; tick(HALF);
        chk("R9", sdo, word[W-1-i]);
        sck = 1'b0; tick(HALF);
        if (i < W - 1) chk("R9 R4", sdo, word[W-2-i]);
        else           chk("R10", sdo, 1'b1);
      end
    end
  endtask

  initial begin
    // R1: busy during and right after reset
    tick(3);
    chk("R1", sdo, 1'b1);
    rst = 1'b0;
    tick(1);
    chk("R1", sdo, 1'b1);
    // R2: exact conversion length (one edge already consumed above)
    tick(CONV - 2);
    chk("R2", sdo, 1'b1);
    tick(1);
    chk("R2", sdo, 1'b0);
    tres = ~16'h5A69;
    readout(1'b1, 16'h5A69);

    foreach (VEC[k]) begin
      cpol = VEC[k][16];
      sck  = VEC[k][16];
      tres = VEC[k][15:0];
      // R3: pulses during conversion must be ignored
      for (int p = 0; p < 3; p++) begin
        sck = ~cpol; tick(5);
        chk("R3", sdo, 1'b1);
        sck = cpol; tick(5);
      end
      tick(CONV);
      tres = ~VEC[k][15:0];
      readout(VEC[k][16], VEC[k][15:0]);
    end

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end
endmodule